// File: doc/BRIEF.md
# Frame-Packing Transfer FIFO

This block buffers serial frames between a 32-bit data port and a serial shift register. Its storage is eight 16-bit stages. The configured frame length decides how many stages each frame takes. A frame of up to 16 bits fits in one stage. A frame of 17 to 32 bits is split over two stages: the low half goes in the first stage and the high half in the next. A full buffer therefore holds eight short frames or four long ones. The fill level is reported in stages, so a long frame moves it by two.

A small controller follows the fill state and decides whether each write or read is accepted. It has three states:

- `ST_EMPTY`: level is zero.
- `ST_PART`: level is between 1 and 7.
- `ST_FULL`: level is eight.

The state changes on these transitions:

- fill: `ST_EMPTY` to `ST_PART` or `ST_FULL`.
- top-up: `ST_PART` to `ST_FULL`.
- drain: `ST_FULL` or `ST_PART` to `ST_EMPTY`.
- partial-drain: `ST_FULL` to `ST_PART`.
- clear: any state to `ST_EMPTY`.

Two request outputs are driven from the level:

- A one-cycle fill pulse marks the level leaving zero. A receive path uses it as its interrupt or DMA trigger.
- A transmit DMA request is held whenever the level is below a programmed threshold.

A clear input empties the buffer and emits a one-cycle pulse. That pulse tells the attached shift register to reset its bit pointer.

Top module: `frame_pack_fifo`

## Requirements
- R1: With `frame_len` of 16 or less, each accepted write raises `level` by 1. Each accepted read lowers it by 1.
- R2: With `frame_len` of 17 or more, each accepted write raises `level` by 2. Each accepted read lowers it by 2.
- R3: A write is ignored when `level` plus the frame's stage count exceeds 8. The level and the stored frames stay unchanged.
- R4: A read is ignored when `level` is below the frame's stage count. The level stays unchanged.
- R5: Frames leave in the order written. `rd_data` shows the oldest frame before it is read.
  - A short frame reads back as the low 16 bits of the written word, with bits 31:16 at zero.
  - A long frame reads back as the full 32 bits.
- R6: `level` never exceeds 8. It updates one clock after the accepted operation.
- R7: `empty` is high exactly when `level` is 0. `full` is high exactly when `level` is 8.
- R8: `fill_irq` is high for one cycle, in the same cycle that `level` first becomes non-zero after being zero. At no other time is it high.
- R9: `tx_dreq` equals `dma_en` AND (`level` < `dma_thr`). This holds for every level and threshold.
- R10: `clr` has priority over `wr_en` and `rd_en`. One clock after `clr`, `level` is 0 and the read pointer is back at the first stage. `sr_clr` is high for exactly that cycle.
- R11: When a read and a write arrive in the same cycle, the write's room is judged on the level before the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the buffer and reset the pointers |
| frame_len | input | 6 | Configured frame length in bits |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Oldest stored frame |
| level | output | 4 | Fill level in stages (0 to 8) |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level is eight |
| fill_irq | output | 1 | Pulse when the level leaves zero |
| dma_en | input | 1 | Transmit DMA request enable |
| dma_thr | input | 4 | Transmit DMA threshold |
| tx_dreq | output | 1 | Transmit DMA request |
| sr_clr | output | 1 | Shift-register pointer clear pulse |

## Verification
Some internal faults show up at the ports on the very next clock:

- A wrong stage count or room check appears as a wrong `level`.
- A wrong controller state appears as wrong `empty` or `full` flags, or as a missing or extra `fill_irq`.

A corrupted read or write pointer does not show up until the affected frame reaches the head, when it appears on `rd_data`. The bench therefore reads every frame back. It also runs the buffer through several pointer wraps in both frame sizes, so that misplaced halves appear within a few operations.

// File: rtl/fpf_pkg.sv
package fpf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_st_t;
endpackage

// File: rtl/fpf_ctrl.sv
module fpf_ctrl
    import fpf_pkg::*;
#(
    parameter int STAGES  = 8,
    parameter int STAGE_W = 16,
    parameter int LEN_W   = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic [LEN_W-1:0]                  frame_len,
    input  logic                              wr_en,
    input  logic                              rd_en,
    output logic                              is_long,
    output logic                              wr_go,
    output logic                              rd_go,
    output logic [$clog2(STAGES+1)-1:0]       lvl,
    output logic                              empty,
    output logic                              full,
    output logic                              fill_irq
);
    localparam int LVL_W = $clog2(STAGES + 1);
    localparam int SUM_W = LVL_W + 1;

    fill_st_t           st_q, st_d;
    logic [LVL_W-1:0]   nxt_lvl;
    logic [SUM_W-1:0]   need, room_sum, after_wr;
    logic               irq_q;

    assign is_long  = (frame_len > LEN_W'(STAGE_W));
    assign need     = is_long ? SUM_W'(2) : SUM_W'(1);
    assign room_sum = SUM_W'(lvl) + need;
    assign wr_go    = wr_en && !clr && (room_sum <= SUM_W'(STAGES));
    assign rd_go    = rd_en && !clr && (SUM_W'(lvl) >= need);

    always_comb begin
        after_wr = SUM_W'(lvl);
        if (wr_go) after_wr = after_wr + need;
        if (rd_go) after_wr = after_wr - need;
        nxt_lvl  = clr ? '0 : after_wr[LVL_W-1:0];
    end

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (nxt_lvl == LVL_W'(STAGES)) st_d = ST_FULL;
                      else if (nxt_lvl != '0)        st_d = ST_PART;
            ST_PART:  if (nxt_lvl == LVL_W'(STAGES)) st_d = ST_FULL;
                      else if (nxt_lvl == '0)        st_d = ST_EMPTY;
            ST_FULL:  if (nxt_lvl == '0)             st_d = ST_EMPTY;
                      else if (nxt_lvl != LVL_W'(STAGES)) st_d = ST_PART;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_EMPTY;
            lvl   <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            lvl   <= nxt_lvl;
            irq_q <= (st_q == ST_EMPTY) && (st_d != ST_EMPTY);
        end
    end

    // output process
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (st_q)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full = 1'b1;
            default:  empty = 1'b1;
        endcase
        fill_irq = irq_q;
    end

    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_W'(STAGES));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_W'(STAGES) && !rd_en && !clr) |=> lvl == LVL_W'(STAGES));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0 && !wr_en && !clr) |=> lvl == '0);
    a_r8_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fill_irq |-> (lvl != '0 && $past(lvl) == '0));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lvl == '0 && empty));
    a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (lvl == '0)) && (full == (lvl == LVL_W'(STAGES))));
endmodule

// File: rtl/fpf_store.sv
module fpf_store #(
    parameter int STAGES  = 8,
    parameter int STAGE_W = 16,
    parameter int PORT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              is_long,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data
);
    localparam int PTR_W = $clog2(STAGES);

    logic [STAGE_W-1:0] mem [STAGES];
    logic [PTR_W-1:0]   wptr, rptr, wptr1, rptr1, step;

    assign step  = is_long ? PTR_W'(2) : PTR_W'(1);
    assign wptr1 = wptr + PTR_W'(1);
    assign rptr1 = rptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_go) wptr <= wptr + step;
            if (rd_go) rptr <= rptr + step;
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_go) begin
                if (wptr == PTR_W'(g))
                    mem[g] <= wr_data[STAGE_W-1:0];
                else if (is_long && wptr1 == PTR_W'(g))
                    mem[g] <= wr_data[PORT_W-1:STAGE_W];
            end
        end
    end

    always_comb begin
        if (is_long) rd_data = {mem[rptr1], mem[rptr]};
        else         rd_data = {{(PORT_W-STAGE_W){1'b0}}, mem[rptr]};
    end

    a_r10_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rptr == '0 && wptr == '0));
    a_r5_read_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !clr && is_long) |=> rptr == $past(rptr) + PTR_W'(2));
endmodule

// File: rtl/fpf_req.sv
module fpf_req #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LVL_W-1:0] lvl,
    input  logic             dma_en,
    input  logic [LVL_W-1:0] dma_thr,
    output logic             tx_dreq,
    output logic             sr_clr
);
    always_ff @(posedge clk) begin
        if (!rst_n) sr_clr <= 1'b0;
        else        sr_clr <= clr;
    end

    assign tx_dreq = dma_en && (lvl < dma_thr);

    a_r10_sr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_clr && !clr) |=> !sr_clr);
    a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !tx_dreq);
endmodule

// File: rtl/frame_pack_fifo.sv
module frame_pack_fifo #(
    parameter int STAGES  = 8,
    parameter int PORT_W  = 32,
    parameter int LEN_W   = 6,
    parameter int LVL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              fill_irq,
    input  logic              dma_en,
    input  logic [LVL_W-1:0]  dma_thr,
    output logic              tx_dreq,
    output logic              sr_clr
);
    localparam int STAGE_W = PORT_W / 2;

    logic is_long, wr_go, rd_go;

    fpf_ctrl #(.STAGES(STAGES), .STAGE_W(STAGE_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frame_len(frame_len),
        .wr_en(wr_en), .rd_en(rd_en), .is_long(is_long),
        .wr_go(wr_go), .rd_go(rd_go), .lvl(level),
        .empty(empty), .full(full), .fill_irq(fill_irq)
    );

    fpf_store #(.STAGES(STAGES), .STAGE_W(STAGE_W), .PORT_W(PORT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .is_long(is_long),
        .wr_go(wr_go), .rd_go(rd_go), .wr_data(wr_data), .rd_data(rd_data)
    );

    fpf_req #(.LVL_W(LVL_W)) u_req (
        .clk(clk), .rst_n(rst_n), .clr(clr), .lvl(level),
        .dma_en(dma_en), .dma_thr(dma_thr), .tx_dreq(tx_dreq), .sr_clr(sr_clr)
    );
endmodule

// File: tb/sim_frame_pack_fifo.sv
module sim_frame_pack_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [5:0]  frame_len = 6'd16;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  level;
    logic        empty, full, fill_irq;
    logic        dma_en = 1'b0;
    logic [3:0]  dma_thr = '0;
    logic        tx_dreq, sr_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    frame_pack_fifo u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frame_len(frame_len),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level), .empty(empty), .full(full), .fill_irq(fill_irq),
        .dma_en(dma_en), .dma_thr(dma_thr), .tx_dreq(tx_dreq), .sr_clr(sr_clr)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // call at a negedge; returns at the next negedge
    task automatic op(input logic w, input logic r, input logic [31:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0000 ^ (i * 32'h0101_3B1D);
    endfunction

    task automatic flags(input int exp_lvl);
        chk("R6 level", level, exp_lvl);
        chk("R7 empty", empty, exp_lvl == 0);
        chk("R7 full", full, exp_lvl == 8);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        flags(0);
        chk("R8 irq at reset", fill_irq, 0);
        chk("R10 sr_clr at reset", sr_clr, 0);

        // R4: read on empty ignored
        op(0, 1, 0);
        flags(0);

        // R1/R3/R8: short frames fill eight stages
        frame_len = 6'd12;
        for (int i = 0; i < 9; i++) begin
            op(1, 0, pat(i));
            flags(i < 8 ? i + 1 : 8);
            chk("R8 irq", fill_irq, i == 0);
        end
        // R11: simultaneous at full -> read taken, write refused
        chk("R5 head short", rd_data, {16'h0, pat(0)[15:0]});
        op(1, 1, 32'hDEAD_BEEF);
        flags(7);
        for (int i = 1; i < 8; i++) begin
            chk("R5 order short", rd_data, {16'h0, pat(i)[15:0]});
            op(0, 1, 0);
            flags(7 - i);
        end
        op(0, 1, 0);
        flags(0);
        chk("R4 read on empty", level, 0);

        // R5 pointer wrap, short mode (pointers start at offset 0 after 8 reads)
        op(1, 0, pat(40));
        for (int i = 0; i < 12; i++) begin
            chk("R5 wrap short", rd_data, {16'h0, pat(40 + i)[15:0]});
            op(1, 1, pat(41 + i));
            flags(1);
        end
        op(0, 1, 0);
        flags(0);

        // R2/R3: long frames, pointers now at odd offset
        frame_len = 6'd32;
        op(1, 0, pat(99));
        op(0, 1, 0);
        for (int i = 0; i < 5; i++) begin
            op(1, 0, pat(60 + i));
            flags(i < 4 ? 2 * (i + 1) : 8);
            chk("R8 irq long", fill_irq, i == 0);
        end
        for (int i = 0; i < 4; i++) begin
            chk("R5 order long", rd_data, pat(60 + i));
            op(0, 1, 0);
            flags(6 - 2 * i);
        end
        // R2 wrap for long frames
        op(1, 0, pat(70));
        for (int i = 0; i < 9; i++) begin
            chk("R5 wrap long", rd_data, pat(70 + i));
            op(1, 1, pat(71 + i));
            flags(2);
        end
        // R4: long read with only one stage left is impossible; level 2 -> 0
        op(0, 1, 0);
        flags(0);
        op(0, 1, 0);
        flags(0);

        // R11 with long: level 6 + read + write -> write refused? 6+2<=8 accepted
        for (int i = 0; i < 3; i++) op(1, 0, pat(80 + i));
        op(1, 1, pat(83));
        flags(6);
        op(1, 0, pat(84));
        flags(8);
        op(1, 1, pat(85));
        flags(6);
        chk("R5 after refused", rd_data, pat(82));

        // R10: clear with competing write
        op(0, 0, 0);
        clr = 1; wr_en = 1; wr_data = pat(90);
        @(negedge clk);
        clr = 0; wr_en = 0;
        flags(0);
        chk("R10 sr_clr pulse", sr_clr, 1);
        @(negedge clk);
        chk("R10 sr_clr gone", sr_clr, 0);
        chk("R10 level held", level, 0);

        // R9: sweep thresholds over every level, short mode
        frame_len = 6'd8;
        for (int l = 0; l <= 8; l++) begin
            if (l > 0) op(1, 0, pat(l));
            for (int t = 0; t < 16; t++) begin
                for (int e = 0; e < 2; e++) begin
                    dma_en = e[0]; dma_thr = t[3:0];
                    #1;
                    chk("R9 dreq", tx_dreq, (e == 1) && (l < t));
                end
            end
        end
        dma_en = 0;
        // R1 read-back after sweep
        chk("R5 sweep head", rd_data, {16'h0, pat(1)[15:0]});

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule